// File: doc/BRIEF.md
# Byte Read-Modify-Write Engine

This block carries out one single-byte read-modify-write operation at a time on behalf of a processor core. A command carries one of five operations: AND, OR, XOR, a bit test, and a test-and-set. It also carries an 8-bit immediate and two 32-bit register values, a base and an index. The engine forms the byte address and reads the byte over a valid/ready memory request channel. It takes the byte back on a valid/ready response channel and computes the new byte and the T flag. When the operation needs it, the engine writes the new byte back to the same address. It then signals completion for one cycle.

From the read request until the last bus access of the operation, the engine holds a lock output high. An arbiter uses this output to keep other masters away from the byte between the read and the write-back. The two test operations produce a T flag. The test-and-set operation also forces bit 7 of the stored byte high. The logical operations never touch T.

Back-pressure works as follows. A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. A memory request counts as accepted in a cycle where `mem_req_valid` and `mem_req_ready` are both high. Until that cycle, the request keeps its address, direction, lane enable and write data unchanged. The response byte is taken in a cycle where `mem_rsp_valid` and `mem_rsp_ready` are both high. A write counts as complete when its request is accepted; no response follows a write.

Top module: `byte_rmw_engine`

## Requirements
- R1: `cmd_ready` is high only when the engine is idle. It is low from the cycle after a command is accepted up to and including the done cycle, and high again in the cycle after done.
- R2: `cmd_op` codes are 0 AND, 1 OR, 2 XOR, 3 TEST and 4 TAS. Codes 5 to 7 are reserved: they perform the read, issue no write and leave `t_we` low.
- R3: For codes 0 to 3 and the reserved codes, the byte address is `cmd_base + cmd_index` modulo 2^32, carries included. For TAS the address is `cmd_index` alone.
- R4: AND, OR and XOR read the byte, then write (byte op `cmd_imm`) to the same address. At done, `t_we` is low and `res_byte` holds the written value.
- R5: TEST issues exactly one read and no write. At done, `t_we` is 1, `t_flag` is 1 exactly when (byte AND `cmd_imm`) is zero, and `res_byte` is the byte read.
- R6: TAS sets `t_flag` to 1 exactly when the byte read is zero. It writes the byte back with bit 7 set, and `t_we` is 1 at done.
- R7: `bus_lock` is high in every cycle in which a request is presented and while a response is awaited. It is low when idle and in the done cycle.
- R8: A request holds `mem_req_addr`, `mem_req_write` and `mem_req_wdata` steady while stalled. `mem_req_be` has exactly one bit set, bit number `mem_req_addr[1:0]`.
- R9: With no stall and no response delay, `done` rises 4 cycles after the accepting edge for writing operations and 3 cycles after it for the others. Each stalled request cycle and each response delay cycle adds one cycle.
- R10: `done` is a one-cycle pulse, and `t_we` is high only together with `done`.
- R11: After reset, `cmd_ready` is high and `mem_req_valid`, `bus_lock` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken on valid and ready |
| cmd_op | input | 3 | Operation code |
| cmd_imm | input | 8 | Immediate operand |
| cmd_base | input | 32 | Base register value |
| cmd_index | input | 32 | Index register, or address for TAS |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_be | output | 4 | One-hot byte lane enable |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read byte offered |
| mem_rsp_ready | output | 1 | Engine waiting for the read byte |
| mem_rsp_data | input | 8 | Read byte |
| bus_lock | output | 1 | Hold off other masters |
| done | output | 1 | Operation complete, one cycle |
| t_we | output | 1 | T flag updated this cycle |
| t_flag | output | 1 | New T value, valid when `t_we` is high |
| res_byte | output | 8 | New byte, or the byte read for TEST and reserved codes |

## Verification
Each operation is run on a byte chosen so that AND, OR and XOR of the same immediate give three different results. A swapped or mis-decoded operation therefore shows up in the written byte. TEST and TAS are each run once on a zero byte and once on a nonzero byte, so that an inverted or missing T flag shows up. One address pair carries out of the low byte, and one TAS command carries a nonzero base that must be ignored; these separate the two addressing forms. Runs with request stalls and response delays must lengthen the latency by exactly their sum. A reserved code must read and must neither write nor raise `t_we`.

// File: rtl/brmw_pkg.sv
package brmw_pkg;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 3;

  localparam logic [OP_W-1:0] OPC_AND  = 3'd0;
  localparam logic [OP_W-1:0] OPC_OR   = 3'd1;
  localparam logic [OP_W-1:0] OPC_XOR  = 3'd2;
  localparam logic [OP_W-1:0] OPC_TEST = 3'd3;
  localparam logic [OP_W-1:0] OPC_TAS  = 3'd4;

  localparam logic [BYTE_W-1:0] TAS_MARK = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RSP,
    ST_WR,
    ST_DONE
  } rmw_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] nbyte;
    logic              wr_need;
    logic              t_upd;
    logic              t_val;
  } rmw_result_t;
endpackage

// File: rtl/brmw_addr_gen.sv
module brmw_addr_gen
  import brmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  logic [OP_W-1:0]   op,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  output logic [ADDR_W-1:0] addr,
  output logic [LANES-1:0]  be
);
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [ADDR_W-1:0] base_sel;

  // TAS addresses through one register only; the others add the index.
  assign base_sel = (op == OPC_TAS) ? '0 : base;
  assign addr     = base_sel + index;

  generate
    if (LANES == 1) begin : g_single_lane
      assign be = '1;
    end else begin : g_lanes
      for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g] = (addr[SEL_W-1:0] == SEL_W'(g));
      end
    end
  endgenerate
endmodule

// File: rtl/brmw_alu.sv
module brmw_alu
  import brmw_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [BYTE_W-1:0] imm,
  input  logic [BYTE_W-1:0] rdata,
  output rmw_result_t       res
);
  always_comb begin
    res.nbyte   = rdata;
    res.wr_need = 1'b0;
    res.t_upd   = 1'b0;
    res.t_val   = 1'b0;
    unique case (op)
      OPC_AND: begin
        res.nbyte   = rdata & imm;
        res.wr_need = 1'b1;
      end
      OPC_OR: begin
        res.nbyte   = rdata | imm;
        res.wr_need = 1'b1;
      end
      OPC_XOR: begin
        res.nbyte   = rdata ^ imm;
        res.wr_need = 1'b1;
      end
      OPC_TEST: begin
        res.t_upd = 1'b1;
        res.t_val = ((rdata & imm) == '0);
      end
      OPC_TAS: begin
        res.nbyte   = rdata | TAS_MARK;
        res.wr_need = 1'b1;
        res.t_upd   = 1'b1;
        res.t_val   = (rdata == '0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/brmw_seq.sv
module brmw_seq
  import brmw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic wr_need,
  output logic cmd_ready,
  output logic req_valid,
  output logic req_write,
  output logic rsp_ready,
  output logic lock,
  output logic done_o
);
  rmw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cmd_valid) state_d = ST_RD;
      ST_RD:   if (req_ready) state_d = ST_RSP;
      ST_RSP:  if (rsp_valid) state_d = wr_need ? ST_WR : ST_DONE;
      ST_WR:   if (req_ready) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign req_valid = (state_q == ST_RD) || (state_q == ST_WR);
  assign req_write = (state_q == ST_WR);
  assign rsp_ready = (state_q == ST_RSP);
  assign lock      = (state_q == ST_RD) || (state_q == ST_RSP) || (state_q == ST_WR);
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/byte_rmw_engine.sv
module byte_rmw_engine
  import brmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [BYTE_W-1:0] cmd_imm,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [ADDR_W-1:0] cmd_index,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LANES-1:0]  mem_req_be,
  output logic [BYTE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [BYTE_W-1:0] mem_rsp_data,
  output logic              bus_lock,
  output logic              done,
  output logic              t_we,
  output logic              t_flag,
  output logic [BYTE_W-1:0] res_byte
);
  logic [OP_W-1:0]   op_q;
  logic [BYTE_W-1:0] imm_q;
  logic [ADDR_W-1:0] addr_q, addr_c;
  logic [LANES-1:0]  be_q, be_c;
  rmw_result_t       res_c, res_q;
  logic              cmd_fire, rsp_fire;

  brmw_addr_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_addr (
    .op    (cmd_op),
    .base  (cmd_base),
    .index (cmd_index),
    .addr  (addr_c),
    .be    (be_c)
  );

  brmw_alu u_alu (
    .op    (op_q),
    .imm   (imm_q),
    .rdata (mem_rsp_data),
    .res   (res_c)
  );

  brmw_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .wr_need   (res_c.wr_need),
    .cmd_ready (cmd_ready),
    .req_valid (mem_req_valid),
    .req_write (mem_req_write),
    .rsp_ready (mem_rsp_ready),
    .lock      (bus_lock),
    .done_o    (done)
  );

  assign cmd_fire = cmd_valid & cmd_ready;
  assign rsp_fire = mem_rsp_valid & mem_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      imm_q  <= '0;
      addr_q <= '0;
      be_q   <= '0;
      res_q  <= '0;
    end else begin
      if (cmd_fire) begin
        op_q   <= cmd_op;
        imm_q  <= cmd_imm;
        addr_q <= addr_c;
        be_q   <= be_c;
      end
      if (rsp_fire) res_q <= res_c;
    end
  end

  assign mem_req_addr  = addr_q;
  assign mem_req_be    = be_q;
  assign mem_req_wdata = res_q.nbyte;
  assign res_byte      = res_q.nbyte;
  assign t_we          = done & res_q.t_upd;
  assign t_flag        = t_we & res_q.t_val;
endmodule

// File: rtl/brmw_checker.sv
module brmw_checker #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [LANES-1:0]  mem_req_be,
  input logic [7:0]        mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic              bus_lock,
  input logic              done,
  input logic              t_we
);
  AST_LOCK_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock |-> !cmd_ready); // R1
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmd_ready); // R1
  AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || mem_rsp_ready) |-> bus_lock); // R7
  AST_DONE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_lock && !mem_req_valid)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata))); // R8
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ($countones(mem_req_be) == 1)); // R8
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid && mem_req_write) |-> $past(mem_rsp_valid && mem_rsp_ready)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_T_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    t_we |-> done); // R10
endmodule

bind byte_rmw_engine brmw_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_be    (mem_req_be),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .bus_lock      (bus_lock),
  .done          (done),
  .t_we          (t_we)
);

// File: tb/sim_byte_rmw_engine.sv
`timescale 1ns/1ps
module sim_byte_rmw_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_imm = '0;
  logic [31:0] cmd_base = '0;
  logic [31:0] cmd_index = '0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [3:0]  mem_req_be;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [7:0]  mem_rsp_data = '0;
  logic        bus_lock, done, t_we, t_flag;
  logic [7:0]  res_byte;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  byte_rmw_engine u0 (.*);

  // memory model state
  logic [7:0]  mem [0:255];
  int          rd_cnt, wr_cnt, lock_viol, ready_viol;
  logic [31:0] last_rd_addr, last_wr_addr;
  logic [7:0]  last_wr_data;
  logic [3:0]  last_be;
  int          stall_cfg = 0, dly_cfg = 0, stall_cnt, rsp_wait;
  bit          rd_pending, rsp_fire_next, busy = 0;
  logic [7:0]  rd_data;

  function automatic logic [7:0] init_byte(input logic [7:0] a);
    return (a[3:0] == 4'hE) ? 8'h00 : 8'(a * 8'h1D + 8'h07);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = init_byte(8'(i));
      rd_cnt = 0; wr_cnt = 0; lock_viol = 0; ready_viol = 0;
      stall_cnt = 0; rsp_wait = 0; rd_pending = 0; rsp_fire_next = 0;
      mem_req_ready = 0; mem_rsp_valid = 0;
      last_rd_addr = '0; last_wr_addr = '0; last_wr_data = '0; last_be = '0;
    end else begin
      if (rsp_fire_next) begin
        mem_rsp_valid = 0; rd_pending = 0; rsp_fire_next = 0;
      end
      if (rd_pending && !mem_rsp_valid) begin
        if (rsp_wait == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = rd_data;
        end else rsp_wait--;
      end
      if (mem_rsp_valid) rsp_fire_next = mem_rsp_ready;
      mem_req_ready = 0;
      if (mem_req_valid) begin
        if (!bus_lock) lock_viol++;
        if (stall_cnt < stall_cfg) stall_cnt++;
        else begin
          stall_cnt = 0;
          mem_req_ready = 1;
          last_be = mem_req_be;
          if (mem_req_write) begin
            mem[mem_req_addr[7:0]] = mem_req_wdata;
            wr_cnt++; last_wr_addr = mem_req_addr; last_wr_data = mem_req_wdata;
          end else begin
            rd_cnt++; last_rd_addr = mem_req_addr;
            rd_pending = 1; rsp_wait = dly_cfg; rd_data = mem[mem_req_addr[7:0]];
          end
        end
      end
      if (busy && cmd_ready) ready_viol++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [7:0] imm,
                        input logic [31:0] base, input logic [31:0] idx,
                        input int s, input int d);
    logic [31:0] ea;
    logic [7:0]  orig, nb;
    bit          wr, tw, tv;
    int          rd0, wr0, lat, exp_lat;
    logic        o_twe, o_tf;
    logic [7:0]  o_res;
    ea   = (op == 3'd4) ? idx : base + idx;
    orig = init_byte(ea[7:0]);
    case (op)
      3'd0: nb = orig & imm;
      3'd1: nb = orig | imm;
      3'd2: nb = orig ^ imm;
      3'd4: nb = orig | 8'h80;
      default: nb = orig;
    endcase
    wr = (op <= 3'd2) || (op == 3'd4);
    tw = (op == 3'd3) || (op == 3'd4);
    tv = (op == 3'd3) ? ((orig & imm) == 8'h00) : (orig == 8'h00);
    exp_lat = wr ? (4 + 2 * s + d) : (3 + s + d);
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    stall_cfg = s; dly_cfg = d;
    cmd_op = op; cmd_imm = imm; cmd_base = base; cmd_index = idx; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0; busy = 1; lat = 1;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    o_twe = t_we; o_tf = t_flag; o_res = res_byte;
    busy = 0;
    chk("R9 latency", lat, exp_lat);
    chk("R3 read address", last_rd_addr, ea);
    chk("R8 lane enable", {28'h0, last_be}, 32'(4'b0001 << ea[1:0]));
    chk("R5 one read", rd_cnt - rd0, 1);
    chk("R2 write count", wr_cnt - wr0, wr ? 1 : 0);
    if (wr) begin
      chk("R4 write address", last_wr_addr, ea);
      chk("R4 write data", {24'h0, last_wr_data}, {24'h0, nb});
    end
    chk("R6 memory byte", {24'h0, mem[ea[7:0]]}, {24'h0, nb});
    chk("R4 res_byte", {24'h0, o_res}, {24'h0, nb});
    chk("R2 t_we", {31'h0, o_twe}, {31'h0, tw});
    if (tw) chk("R5 t_flag", {31'h0, o_tf}, {31'h0, tv});
    @(negedge clk);
    chk("R10 done pulse", {31'h0, done}, 32'h0);
    chk("R1 ready after done", {31'h0, cmd_ready}, 32'h1);
    chk("R7 lock released", {31'h0, bus_lock}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R11 cmd_ready", {31'h0, cmd_ready}, 32'h1);
    chk("R11 req_valid", {31'h0, mem_req_valid}, 32'h0);
    chk("R11 bus_lock", {31'h0, bus_lock}, 32'h0);
    chk("R11 done", {31'h0, done}, 32'h0);
  endtask

  task automatic t_and;      run_op(3'd0, 8'h3C, 32'h1000_0040, 32'h0000_0003, 0, 0); endtask
  task automatic t_or_carry; run_op(3'd1, 8'hC0, 32'h2000_00FF, 32'h0000_0002, 0, 0); endtask
  task automatic t_xor_stall;run_op(3'd2, 8'hFF, 32'h0000_0008, 32'h0000_0008, 2, 1); endtask
  task automatic t_test_zero;run_op(3'd3, 8'h0F, 32'h0000_0020, 32'h0000_000E, 0, 0); endtask
  task automatic t_test_hit; run_op(3'd3, 8'hFF, 32'h0000_0020, 32'h0000_0002, 1, 2); endtask
  task automatic t_tas_zero; run_op(3'd4, 8'h00, 32'hDEAD_0000, 32'h3000_005E, 0, 0); endtask
  task automatic t_tas_set;  run_op(3'd4, 8'h00, 32'h0000_0011, 32'h0000_0066, 1, 0); endtask
  task automatic t_reserved; run_op(3'd6, 8'hAA, 32'h0000_0060, 32'h0000_0010, 0, 0); endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_and();
    t_or_carry();
    t_xor_stall();
    t_test_zero();
    t_test_hit();
    t_tas_zero();
    t_tas_set();
    t_reserved();
    chk("R7 request without lock", lock_viol, 0);
    chk("R1 ready while busy", ready_viol, 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule